// File: doc/BRIEF.md
# Interprocessor Message Register with Acknowledge

This block keeps one 64-bit message word replicated in each of up to four processors. Processors use it to pass short commands to each other without going through main storage. A broadcast write reaches every copy in the same cycle. When the write has its exception flag set, it loads a new command, data payload and target mask into all copies. Each processor named in the target mask then raises its interrupt line.

The target mask has a second role: it also records which acknowledgements are still outstanding. A receiver acknowledges by clearing its own mask bit. The clear lands in every copy in the same cycle and needs no lock. While any mask bit is still set, the register is busy. An exception write that arrives while the register is busy is dropped and flagged on the reject output. A write with the exception flag clear only clears the mask bits it names. It leaves the payload untouched. The bus that carries the writes and the interrupt handlers are outside this block.

Top module: `ipmsg_reg`

## Requirements
- R1: After reset every copy reads all zeros, and irq, busy and reject are low.
- R2: The word layout is as follows. The payload sits in bits 55:16 (40 bits). The command sits in bits 57:56. The exception flag is bit 58 of a write. The target mask is bits 63:60, where bit 60+i names processor i. Bits 15:0, 58 and 59 always read as zero, whatever the write carries there.
- R3: A write with bit 58 set, made while the register is not busy, loads payload, command and target mask into every copy on the next clock edge.
- R4: irq[i] is high from the cycle after a load that names processor i, and stays high until mask bit i is cleared.
- R5: A write with bit 58 clear clears each mask bit that is 1 in its bits 63:60. It leaves the payload and command unchanged.
- R6: ack_req[i] clears mask bit i in every copy on the next edge and leaves the other bits alone. Acknowledge requests and a clearing write in the same cycle take effect together.
- R7: busy is high exactly when any mask bit is set.
- R8: An exception write made while busy changes nothing in the payload, command or mask. Acknowledges in the same cycle still apply. reject is high for exactly the one cycle that follows the write.
- R9: All copies hold identical contents at all times.
- R10: An exception write whose target mask is zero loads payload and command, but leaves busy low and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Broadcast write strobe |
| wr_word | input | 64 | Broadcast write word (layout per R2) |
| ack_req | input | NCPU | Per-processor acknowledge request |
| msg_image | output | NCPU*64 | Contents of every copy; copy i in bits 64*i+63 down to 64*i |
| irq | output | NCPU | Interrupt line per processor |
| busy | output | 1 | A message is awaiting acknowledgement |
| reject | output | 1 | The exception write in the previous cycle was refused |

## Verification
The bench aims at the following corner cases:

- **Exception write while busy.** A design that loads anyway would overwrite a message that is still pending. A design that forgets the flag would drop the write with no trace.
- **Clearing write with payload bits set.** A design that treats it as a load would corrupt the payload.
- **Acknowledges in the same cycle as a clearing write.** A design that lets one of them win would leave a stale mask bit, and with it a stuck interrupt and a register that stays busy.
- **Load with an empty target mask.** A faulty design would report busy or raise an interrupt here.
- **Garbage in reserved bits.** A write carries junk in bits 15:0 and 59, and such bits must never appear in a copy.

// File: rtl/ipmsg_pkg.sv
package ipmsg_pkg;

    localparam int WORD_W  = 64;
    localparam int DATA_LSB = 16;
    localparam int DATA_W  = 40;
    localparam int CMD_LSB = 56;
    localparam int CMD_W   = 2;
    localparam int EXC_BIT = 58;
    localparam int ID_LSB  = 60;
    localparam int ID_W    = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [ID_W-1:0]   id_t;
    typedef logic [WORD_W-1:0] word_t;

    // contents held by one copy
    typedef struct packed {
        data_t data;
        cmd_t  cmd;
        id_t   ids;
    } msg_t;

    // decoded broadcast write
    typedef struct packed {
        logic load;
        logic clear;
        msg_t msg;
    } wr_dec_t;

    // build the readable word; unused and reserved positions read zero
    function automatic word_t pack_image(msg_t m);
        word_t w;
        w = '0;
        w[DATA_LSB +: DATA_W] = m.data;
        w[CMD_LSB  +: CMD_W]  = m.cmd;
        w[ID_LSB   +: ID_W]   = m.ids;
        return w;
    endfunction

endpackage

// File: rtl/ipmsg_decode.sv
module ipmsg_decode
    import ipmsg_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic    wr_valid,
    input  word_t   wr_word,
    output wr_dec_t dec
);

    localparam id_t ID_KEEP = id_t'((1 << NCPU) - 1);

    always_comb begin
        dec          = '0;
        dec.msg.data = wr_word[DATA_LSB +: DATA_W];
        dec.msg.cmd  = wr_word[CMD_LSB  +: CMD_W];
        dec.msg.ids  = wr_word[ID_LSB   +: ID_W] & ID_KEEP;
        dec.load     = wr_valid &  wr_word[EXC_BIT];
        dec.clear    = wr_valid & ~wr_word[EXC_BIT];
    end

endmodule

// File: rtl/ipmsg_copy.sv
module ipmsg_copy
    import ipmsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take_load,
    input  msg_t  load_msg,
    input  id_t   clr_mask,
    output word_t image,
    output id_t   ids
);

    msg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take_load) begin
            s_d = load_msg;
        end else begin
            s_d.ids = s_q.ids & ~clr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign image = pack_image(s_q);
    assign ids   = s_q.ids;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        take_load |=> (s_q == $past(load_msg)));                       // R3
    AST_KEEP_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_load |=> ($stable(s_q.data) && $stable(s_q.cmd)));       // R5
    AST_IDS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_load |=> ((s_q.ids & ~$past(s_q.ids)) == '0));           // R6
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        !take_load |=> ((s_q.ids & $past(clr_mask)) == '0));           // R6

endmodule

// File: rtl/ipmsg_reg.sv
module ipmsg_reg
    import ipmsg_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [63:0]            wr_word,
    input  logic [NCPU-1:0]        ack_req,
    output logic [NCPU*64-1:0]     msg_image,
    output logic [NCPU-1:0]        irq,
    output logic                   busy,
    output logic                   reject
);

    typedef struct packed {
        logic reject;
    } top_t;

    wr_dec_t dec;
    id_t     ack_ext;
    id_t     clr_mask;
    logic    take_load;
    logic    busy_int;
    top_t    t_d, t_q;
    word_t   copy_img [NCPU];
    id_t     copy_ids [NCPU];

    ipmsg_decode #(.NCPU(NCPU)) u_dec (
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .dec      (dec)
    );

    assign busy_int = |copy_ids[0];

    always_comb begin
        ack_ext = '0;
        ack_ext[NCPU-1:0] = ack_req;
        take_load = dec.load & ~busy_int;
        clr_mask  = ack_ext | (dec.clear ? dec.msg.ids : id_t'(0));
        t_d       = t_q;
        t_d.reject = dec.load & busy_int;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar i = 0; i < NCPU; i++) begin : g_copy
        ipmsg_copy u_copy (
            .clk       (clk),
            .rst_n     (rst_n),
            .take_load (take_load),
            .load_msg  (dec.msg),
            .clr_mask  (clr_mask),
            .image     (copy_img[i]),
            .ids       (copy_ids[i])
        );
        assign msg_image[i*WORD_W +: WORD_W] = copy_img[i];
        assign irq[i] = copy_ids[i][i];

        AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            copy_img[i] == copy_img[0]);                                 // R9
    end

    assign busy   = busy_int;
    assign reject = t_q.reject;

    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.load && busy_int) |=> reject);                              // R8
    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.load && busy_int) |=> !reject);                            // R8
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.load && busy_int) |=> $stable(copy_img[0][59:16]));         // R8
    AST_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> busy);                                                // R7
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_img[0][15:0] == '0) && (copy_img[0][59:58] == '0));        // R2

endmodule

// File: tb/tb_ipmsg_reg.sv
module tb_ipmsg_reg;

    localparam int NCPU = 4;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM = 3000;
    localparam int WATCHDOG = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [63:0]       wr_word = '0;
    logic [NCPU-1:0]   ack_req = '0;
    logic [NCPU*64-1:0] msg_image;
    logic [NCPU-1:0]   irq;
    logic              busy;
    logic              reject;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model
    logic [39:0] m_data = '0;
    logic [1:0]  m_cmd  = '0;
    logic [3:0]  m_ids  = '0;
    logic        m_rej  = 1'b0;

    ipmsg_reg #(.NCPU(NCPU)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_word   (wr_word),
        .ack_req   (ack_req),
        .msg_image (msg_image),
        .irq       (irq),
        .busy      (busy),
        .reject    (reject)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] exp_image();
        return {m_ids, 2'b00, m_cmd, m_data, 16'h0000};
    endfunction

    function automatic logic [63:0] mk_word(logic exc, logic [3:0] ids,
                                            logic [1:0] cmd, logic [39:0] data,
                                            logic rsv, logic [15:0] low);
        return {ids, rsv, exc, cmd, data, low};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < NCPU; i++)
            chk($sformatf("%s/R9 copy%0d", tag, i), msg_image[i*64 +: 64], exp_image());
        chk({tag, "/R4 irq"}, 64'(irq), 64'(m_ids));
        chk({tag, "/R7 busy"}, 64'(busy), 64'(m_ids != 0));
        chk({tag, "/R8 reject"}, 64'(reject), 64'(m_rej));
    endtask

    // called just after a falling edge; returns at the next falling edge
    task automatic cycle(logic v, logic [63:0] w, logic [NCPU-1:0] a);
        logic [3:0] clr;
        wr_valid = v;
        wr_word  = w;
        ack_req  = a;
        m_rej = 1'b0;
        if (v && w[58]) begin
            if (m_ids != 0) begin
                m_rej = 1'b1;
                m_ids = m_ids & ~4'(a);
            end else begin
                m_data = w[55:16];
                m_cmd  = w[57:56];
                m_ids  = w[63:60];
            end
        end else begin
            clr = 4'(a) | (v ? w[63:60] : 4'h0);
            m_ids = m_ids & ~clr;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_word  = '0;
        ack_req  = '0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h1bad5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2, R3: load with junk in reserved positions
        cycle(1'b1, mk_word(1'b1, 4'b0101, 2'd2, 40'hA5_1234_5678, 1'b1, 16'hFFFF), '0);
        check_all("R2 R3 load");
        // R4: interrupts persist across idle cycles
        cycle(1'b0, '0, '0);
        check_all("R4 hold");
        // R8: exception write while busy
        cycle(1'b1, mk_word(1'b1, 4'b1111, 2'd1, 40'h00_DEAD_BEEF, 1'b0, 16'h0), '0);
        check_all("R8 reject");
        cycle(1'b0, '0, '0);
        check_all("R8 pulse");
        // R5: clearing write with payload bits set
        cycle(1'b1, mk_word(1'b0, 4'b0001, 2'd3, 40'hFF_FFFF_FFFF, 1'b1, 16'h1234), '0);
        check_all("R5 clear");
        // R6: acknowledge from processor 2
        cycle(1'b0, '0, 4'b0100);
        check_all("R6 ack");
        // R10: load with empty target mask
        cycle(1'b1, mk_word(1'b1, 4'b0000, 2'd1, 40'h12_3456_789A, 1'b0, 16'h0), '0);
        check_all("R10 empty");
        // R6: acknowledge and clearing write together
        cycle(1'b1, mk_word(1'b1, 4'b1111, 2'd0, 40'h01_0203_0405, 1'b0, 16'h0), '0);
        check_all("R3 full");
        cycle(1'b1, mk_word(1'b0, 4'b1000, 2'd0, 40'h0, 1'b0, 16'h0), 4'b0001);
        check_all("R6 combined");
        // R8: rejected load with simultaneous acknowledge
        cycle(1'b1, mk_word(1'b1, 4'b0001, 2'd2, 40'h77_7777_7777, 1'b0, 16'h0), 4'b0010);
        check_all("R8 reject ack");

        for (int n = 0; n < N_RANDOM; n++) begin
            logic v;
            logic [63:0] w;
            logic [NCPU-1:0] a;
            v = ($urandom % 2) == 0;
            w = {$urandom, $urandom};
            w[58] = ($urandom % 3) == 0;
            a = '0;
            for (int k = 0; k < NCPU; k++)
                a[k] = ($urandom % 5) == 0;
            cycle(v, w, a);
            check_all(v && w[58] ? "R3 rnd" : "R6 rnd");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule